// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Controller

This block owns the stack pointer of a small microcontroller core and drives a byte-wide data SRAM port for all stack traffic. The core presents one request at a time: a single data byte to push or pop, or a 16-bit return address to push or pop for call, interrupt, return and interrupt-return sequences. The block generates the SRAM address, write data, write enable and read strobe. It returns a popped byte, or it rebuilds the two bytes of a return address into one 16-bit value.

The stack grows toward lower addresses. Pushes write at the current pointer and then decrement it. Pops increment the pointer first and then read. A data byte moves the pointer by one and a return address moves it by two, over two clock cycles. During the second of those cycles a busy flag is raised and further requests are dropped. Software can read the pointer at any time and can overwrite it. A software write wins over any stack request in the same cycle. The pointer resets to a top-of-RAM value. An error flag reports whenever the pointer has reached the floor of the usable region or gone below it.

Top module: `dstk_ctrl`

## Requirements
- R1: After reset the pointer reads TOP (default 0xDF), busy and bound_err are low, pop_valid and ret_valid are low, and there is no memory access.
- R2: op_kind 0 (byte push) accepted with pointer S writes push_byte to address S in that cycle, and the pointer reads S-1 after the clock edge.
- R3: op_kind 1 (byte pop) accepted with pointer S reads address S+1 in that cycle. After the edge the pointer reads S+1, and for one cycle pop_valid is high with pop_byte equal to the byte read.
- R4: op_kind 2 (return push) accepted with pointer S writes push_ret[7:0] at S. In the following cycle busy is high and push_ret[15:8] is written at S-1. Afterwards the pointer reads S-2.
- R5: op_kind 3 (return pop) accepted with pointer S reads the high byte from S+1 and then, in the busy cycle, the low byte from S+2. For one cycle after that, ret_valid is high with ret_addr equal to {high, low}, and the pointer reads S+2.
- R6: A request presented while busy is high is ignored. The pointer and memory change only as the ongoing return operation dictates, and busy lasts exactly one cycle.
- R7: sw_we loads sw_wdata into the pointer at the next edge. A request in the same cycle is dropped with no memory access. A sw_we during the busy cycle cancels the second access and clears busy.
- R8: sp_rd always shows the current pointer value.
- R9: bound_err is high exactly when the pointer is at or below FLOOR (default 0x60).
- R10: mem_we and mem_re are never high together, and every write goes to the current pointer while every read goes to the pointer plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Stack request present |
| op_kind | input | 2 | 0 byte push, 1 byte pop, 2 return push, 3 return pop |
| push_byte | input | 8 | Data byte for a byte push |
| push_ret | input | 16 | Return address for a return push |
| sw_we | input | 1 | Software write of the pointer |
| sw_wdata | input | 8 | New pointer value |
| sp_rd | output | 8 | Current pointer value |
| busy | output | 1 | Second cycle of a two-byte operation |
| bound_err | output | 1 | Pointer at or below the floor |
| mem_addr | output | 8 | SRAM address |
| mem_wdata | output | 8 | SRAM write data |
| mem_we | output | 1 | SRAM write enable |
| mem_re | output | 1 | SRAM read strobe |
| mem_rdata | input | 8 | SRAM read data, valid in the same cycle as the address |
| pop_valid | output | 1 | pop_byte is valid this cycle |
| pop_byte | output | 8 | Popped data byte |
| ret_valid | output | 1 | ret_addr is valid this cycle |
| ret_addr | output | 16 | Reassembled return address |

## Verification
The hardest states to reach from the ports are the collisions in the busy cycle: a new request that arrives while busy is high, and a software pointer write that lands either on that cycle or on the same edge as a fresh request. The bench produces each of these by driving the inputs cycle by cycle around a return push. It then checks the pointer and preloaded memory cells that a wrongly accepted access would have overwritten. The floor boundary is swept by pushing bytes from the reset value down through 0x60 and popping them all back.

// File: rtl/dstk_pkg.sv
package dstk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH_B = 2'd0,
    OP_POP_B  = 2'd1,
    OP_PUSH_R = 2'd2,
    OP_POP_R  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_PUSH_HI = 2'd1,
    PH_POP_LO  = 2'd2
  } phase_e;
endpackage

// File: rtl/dstk_seq.sv
module dstk_seq
  import dstk_pkg::*;
#(
  parameter int unsigned PW  = 8,
  parameter int unsigned TOP = 223
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic          sw_we,
  input  logic [PW-1:0] sw_wdata,
  output logic [PW-1:0] sp_q,
  output phase_e        phase_q,
  output logic          acc,
  output op_e           acc_kind
);
  localparam logic [PW-1:0] TOP_V = PW'(TOP);
  localparam logic [PW-1:0] ONE   = PW'(1);

  phase_e        phase_n;
  logic [PW-1:0] sp_n;
  logic          step_dn, step_up;

  always_comb begin
    acc_kind = op_e'(op_kind);
    acc      = op_valid && (phase_q == PH_IDLE) && !sw_we;

    step_dn = !sw_we && ((acc && (acc_kind == OP_PUSH_B || acc_kind == OP_PUSH_R))
                         || phase_q == PH_PUSH_HI);
    step_up = !sw_we && ((acc && (acc_kind == OP_POP_B || acc_kind == OP_POP_R))
                         || phase_q == PH_POP_LO);

    phase_n = PH_IDLE;
    if (acc && acc_kind == OP_PUSH_R) phase_n = PH_PUSH_HI;
    if (acc && acc_kind == OP_POP_R)  phase_n = PH_POP_LO;

    sp_n = sp_q;
    if (sw_we)        sp_n = sw_wdata;
    else if (step_dn) sp_n = sp_q - ONE;
    else if (step_up) sp_n = sp_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= TOP_V;
      phase_q <= PH_IDLE;
    end else begin
      sp_q    <= sp_n;
      phase_q <= phase_n;
    end
  end
endmodule

// File: rtl/dstk_port.sv
module dstk_port
  import dstk_pkg::*;
#(
  parameter int unsigned PW = 8,
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_we,
  input  phase_e          phase_q,
  input  logic            acc,
  input  op_e             acc_kind,
  input  logic [PW-1:0]   sp_q,
  input  logic [DW-1:0]   push_byte,
  input  logic [2*DW-1:0] push_ret,
  output logic [PW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [DW-1:0] hi_q, hi_n;
  logic          hi_en;

  always_comb begin
    mem_addr  = sp_q;
    mem_wdata = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    hi_en     = acc && acc_kind == OP_PUSH_R;
    hi_n      = push_ret[2*DW-1:DW];
    if (acc) begin
      unique case (acc_kind)
        OP_PUSH_B: begin mem_we = 1'b1; mem_wdata = push_byte; end
        OP_PUSH_R: begin mem_we = 1'b1; mem_wdata = push_ret[DW-1:0]; end
        OP_POP_B, OP_POP_R: begin mem_re = 1'b1; mem_addr = sp_q + ONE; end
        default: ;
      endcase
    end else if (!sw_we && phase_q == PH_PUSH_HI) begin
      mem_we    = 1'b1;
      mem_wdata = hi_q;
    end else if (!sw_we && phase_q == PH_POP_LO) begin
      mem_re   = 1'b1;
      mem_addr = sp_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= hi_n;
  end
endmodule

// File: rtl/dstk_capture.sv
module dstk_capture #(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_byte,
  input  logic            cap_hi,
  input  logic            cap_lo,
  input  logic [DW-1:0]   rdata,
  output logic            pop_valid,
  output logic [DW-1:0]   pop_byte,
  output logic            ret_valid,
  output logic [2*DW-1:0] ret_addr
);
  logic [DW-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_valid <= 1'b0;
      ret_valid <= 1'b0;
    end else begin
      pop_valid <= cap_byte;
      ret_valid <= cap_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_byte <= '0;
      hi_q     <= '0;
      ret_addr <= '0;
    end else begin
      if (cap_byte) pop_byte <= rdata;
      if (cap_hi)   hi_q     <= rdata;
      if (cap_lo)   ret_addr <= {hi_q, rdata};
    end
  end
endmodule

// File: rtl/dstk_ctrl.sv
module dstk_ctrl
  import dstk_pkg::*;
#(
  parameter int unsigned PW    = 8,
  parameter int unsigned DW    = 8,
  parameter int unsigned TOP   = 223,
  parameter int unsigned FLOOR = 96
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [1:0]      op_kind,
  input  logic [DW-1:0]   push_byte,
  input  logic [2*DW-1:0] push_ret,
  input  logic            sw_we,
  input  logic [PW-1:0]   sw_wdata,
  output logic [PW-1:0]   sp_rd,
  output logic            busy,
  output logic            bound_err,
  output logic [PW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  input  logic [DW-1:0]   mem_rdata,
  output logic            pop_valid,
  output logic [DW-1:0]   pop_byte,
  output logic            ret_valid,
  output logic [2*DW-1:0] ret_addr
);
  localparam logic [PW-1:0] FLOOR_V = PW'(FLOOR);

  logic [1:0]    rst_sync;
  logic          rst_i;
  logic [PW-1:0] sp_q;
  phase_e        phase_q;
  logic          acc;
  op_e           acc_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  dstk_seq #(.PW(PW), .TOP(TOP)) seq_i (
    .clk(clk), .rst_n(rst_i), .op_valid(op_valid), .op_kind(op_kind),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .sp_q(sp_q), .phase_q(phase_q),
    .acc(acc), .acc_kind(acc_kind)
  );

  dstk_port #(.PW(PW), .DW(DW)) port_i (
    .clk(clk), .rst_n(rst_i), .sw_we(sw_we), .phase_q(phase_q), .acc(acc),
    .acc_kind(acc_kind), .sp_q(sp_q), .push_byte(push_byte), .push_ret(push_ret),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re)
  );

  dstk_capture #(.DW(DW)) cap_i (
    .clk(clk), .rst_n(rst_i),
    .cap_byte(acc && acc_kind == OP_POP_B),
    .cap_hi(acc && acc_kind == OP_POP_R),
    .cap_lo(!sw_we && phase_q == PH_POP_LO),
    .rdata(mem_rdata),
    .pop_valid(pop_valid), .pop_byte(pop_byte),
    .ret_valid(ret_valid), .ret_addr(ret_addr)
  );

  assign sp_rd     = sp_q;
  assign busy      = (phase_q != PH_IDLE);
  assign bound_err = (sp_q <= FLOOR_V);
endmodule

// File: rtl/dstk_ctrl_chk.sv
module dstk_ctrl_chk #(
  parameter int unsigned PW = 8,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [1:0]    op_kind,
  input logic          sw_we,
  input logic [PW-1:0] sw_wdata,
  input logic [PW-1:0] sp_rd,
  input logic          busy,
  input logic [PW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re
);
  localparam logic [PW-1:0] ONE = PW'(1);

  // R2
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && !sw_we && op_kind == 2'd0) |=> sp_rd == $past(sp_rd) - ONE);

  // R4
  ret_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && !sw_we && op_kind == 2'd2) |=> busy);

  // R6
  busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R7
  sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> sp_rd == $past(sw_wdata));

  // R10
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R10
  wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr == sp_rd);

  // R10
  rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> mem_addr == sp_rd + ONE);
endmodule

bind dstk_ctrl dstk_ctrl_chk #(.PW(PW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
  .sw_we(sw_we), .sw_wdata(sw_wdata), .sp_rd(sp_rd), .busy(busy),
  .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/dstk_ctrl_tb_top.sv
module dstk_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic [7:0]  push_byte = 8'h00;
  logic [15:0] push_ret = 16'h0000;
  logic        sw_we = 1'b0;
  logic [7:0]  sw_wdata = 8'h00;
  logic [7:0]  sp_rd, mem_addr, mem_wdata, mem_rdata, pop_byte;
  logic        busy, bound_err, mem_we, mem_re, pop_valid, ret_valid;
  logic [15:0] ret_addr;

  logic        tb_we = 1'b0;
  logic [7:0]  tb_addr = 8'h00, tb_data = 8'h00;
  logic [7:0]  mem [0:255];

  int tests = 0, fails = 0;
  bit done = 1'b0;
  bit busy_seen;

  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (mem_we)     mem[mem_addr] <= mem_wdata;
    else if (tb_we) mem[tb_addr]  <= tb_data;
  end

  dstk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .push_byte(push_byte), .push_ret(push_ret), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .sp_rd(sp_rd), .busy(busy), .bound_err(bound_err), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .pop_valid(pop_valid), .pop_byte(pop_byte), .ret_valid(ret_valid), .ret_addr(ret_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic set_sp(input logic [7:0] v);
    @(negedge clk); sw_we = 1'b1; sw_wdata = v;
    @(negedge clk); sw_we = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] k, input logic [7:0] b, input logic [15:0] r);
    @(negedge clk); op_valid = 1'b1; op_kind = k; push_byte = b; push_ret = r;
    @(negedge clk); op_valid = 1'b0;
    busy_seen = busy;
    if (k[1]) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_sp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R8: reset state
    chk(sp_rd == 8'hDF, "R1 R8 reset pointer", sp_rd, 8'hDF);
    chk(!busy && !bound_err, "R1 reset flags", {busy, bound_err}, 0);
    chk(!pop_valid && !ret_valid && !mem_we && !mem_re, "R1 idle outputs",
        {pop_valid, ret_valid, mem_we, mem_re}, 0);

    // R2 / R9: push sweep from top through the floor
    exp_sp = 8'hDF;
    for (int i = 0; i < 130; i++) begin
      logic [7:0] b;
      b = exp_sp ^ 8'hA5;
      do_op(2'd0, b, 16'h0);
      chk(mem[exp_sp] == b, "R2 push data", mem[exp_sp], b);
      exp_sp = exp_sp - 8'd1;
      chk(sp_rd == exp_sp, "R2 push pointer", sp_rd, exp_sp);
      chk(bound_err == (exp_sp <= 8'h60), "R9 floor flag", bound_err, exp_sp <= 8'h60);
    end

    // R3 / R9: pop sweep back to top
    for (int i = 0; i < 130; i++) begin
      exp_sp = exp_sp + 8'd1;
      do_op(2'd1, 8'h00, 16'h0);
      chk(pop_valid && pop_byte == (exp_sp ^ 8'hA5), "R3 pop data",
          {pop_valid, pop_byte}, {1'b1, exp_sp ^ 8'hA5});
      chk(sp_rd == exp_sp, "R3 pop pointer", sp_rd, exp_sp);
      chk(bound_err == (exp_sp <= 8'h60), "R9 floor flag pop", bound_err, exp_sp <= 8'h60);
    end
    @(negedge clk);
    chk(!pop_valid, "R3 pop_valid one cycle", pop_valid, 0);

    // R4 / R5: return address round trips at several pointers
    for (int k = 0; k < 8; k++) begin
      logic [7:0]  s;
      logic [15:0] v;
      s = 8'hD0 - 8'(5 * k);
      v = 16'(16'h1357 * (k + 1)) ^ 16'hC3A0;
      set_sp(s);
      chk(sp_rd == s, "R7 R8 sw load", sp_rd, s);
      do_op(2'd2, 8'h00, v);
      chk(busy_seen, "R4 busy in second cycle", busy_seen, 1);
      chk(mem[s] == v[7:0] && mem[s-8'd1] == v[15:8], "R4 byte order",
          {mem[s], mem[s-8'd1]}, {v[7:0], v[15:8]});
      chk(sp_rd == s - 8'd2 && !busy, "R4 pointer", sp_rd, s - 8'd2);
      do_op(2'd3, 8'h00, 16'h0);
      chk(busy_seen, "R5 busy in second cycle", busy_seen, 1);
      chk(ret_valid && ret_addr == v, "R5 return address", ret_addr, v);
      chk(sp_rd == s, "R5 pointer", sp_rd, s);
      @(negedge clk);
      chk(!ret_valid, "R5 ret_valid one cycle", ret_valid, 0);
    end

    // R6: request during busy is ignored
    set_sp(8'hC0);
    poke(8'hBE, 8'h77);
    @(negedge clk); op_valid = 1'b1; op_kind = 2'd2; push_ret = 16'hBEEF;
    @(negedge clk); op_kind = 2'd0; push_byte = 8'h11;
    chk(busy, "R6 busy raised", busy, 1);
    @(negedge clk); op_valid = 1'b0;
    chk(sp_rd == 8'hBE, "R6 pointer unchanged by busy request", sp_rd, 8'hBE);
    chk(mem[8'hBE] == 8'h77, "R6 memory untouched", mem[8'hBE], 8'h77);
    chk(mem[8'hBF] == 8'hBE && mem[8'hC0] == 8'hEF, "R6 return bytes",
        {mem[8'hBF], mem[8'hC0]}, 16'hBEEF);

    // R7: software write beats a same-cycle request
    @(negedge clk); op_valid = 1'b1; op_kind = 2'd0; push_byte = 8'h22;
    sw_we = 1'b1; sw_wdata = 8'h90;
    chk(!mem_we, "R7 no write on collision", mem_we, 0);
    @(negedge clk); op_valid = 1'b0; sw_we = 1'b0;
    chk(sp_rd == 8'h90, "R7 priority pointer", sp_rd, 8'h90);
    chk(mem[8'hBE] == 8'h77, "R7 dropped push", mem[8'hBE], 8'h77);

    // R7: software write in busy cycle cancels the second byte
    poke(8'h8F, 8'h55);
    @(negedge clk); op_valid = 1'b1; op_kind = 2'd2; push_ret = 16'hA1B2;
    @(negedge clk); op_valid = 1'b0; sw_we = 1'b1; sw_wdata = 8'hA0;
    @(negedge clk); sw_we = 1'b0;
    chk(sp_rd == 8'hA0 && !busy, "R7 cancel pointer", sp_rd, 8'hA0);
    chk(mem[8'h8F] == 8'h55, "R7 cancel second write", mem[8'h8F], 8'h55);
    chk(mem[8'h90] == 8'hB2, "R7 first byte kept", mem[8'h90], 8'hB2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule